// File: doc/BRIEF.md
# Regulator Configuration Register Slave on a Two-Wire Bus

This block is the digital side of a voltage regulator controller. A host reaches it over a two-wire serial bus in the I2C style: an open-drain clock line and an open-drain data line. Behind the bus sit four registers:

- an offset code that raises the regulator setpoint in 25 mV steps;
- a read-only view of the measured core current;
- a control/status register holding the watchdog-reset enable and two flags that can only be cleared;
- a read-only revision byte.

The bus lines are brought into the system clock domain through synchronizers. Edges and start/stop conditions are detected there. A byte-level engine turns each transfer into single-register writes or reads. The data line is driven low through an open-drain enable output and is never driven high.

Two board-level events return registers to their defaults. The first is a socket-change input that clears everything. The second is a low pulse from the watchdog, which is honoured only when enabled and spares the control register.

Top module: `vreg_cfg_slave`

## Requirements
- R1: After the synchronous reset, index 0x00 reads 0x00, index 0x03 reads 0x04, index 0x13 reads 0x00, `offset_code_o`, `offset_mv_o` and `wd_enable_o` are 0, and `sda_drive_o` is low.
- R2: The 7-bit device address is 0x2F when `addr_sel_i` is 1 and 0x2E when it is 0, so the write address bytes are 0x5E and 0x5C. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R3: A write to index 0x00 stores data bits 4:0 as the offset code, and bits 7:5 are dropped. A read of index 0x00 returns the code with bits 7:5 as 0, and `offset_code_o` shows the code.
- R4: `offset_mv_o` equals 25 times the offset code for codes 0 to 30, and equals 800 for code 31.
- R5: Index 0x01 reads `core_current_i` in bits 6:0 with bit 7 as 0, and writes to it are ignored.
- R6: In index 0x03, bit 0 (watchdog-reset enable, also on `wd_enable_o`) is read/write. Bit 1 (reset issued) and bit 2 (socket line seen high) clear when written 0 and keep their value when written 1.
- R7: Index 0x13 reads 0x00. Unimplemented indices read 0x00. Writes to read-only or unimplemented indices change no register.
- R8: A high level on `socket_occ_i` returns every register to its default, including index 0x03 (0x04).
- R9: While index 0x03 bit 0 is 1, a low level on `wd_rst_n_i` clears the offset code and sets bit 1, and leaves bit 0 at 1. While bit 0 is 0, a low `wd_rst_n_i` has no effect.
- R10: A write transfer is start, address byte with R/W=0, index byte, then data bytes, and the slave acknowledges the address and every written byte. A read is start, address byte, index byte, repeated start, address byte with R/W=1, then data bytes sent MSB first. A master ACK makes the slave send the same register again, and a master NACK ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap selecting the device address low bit |
| socket_occ_i | input | 1 | Socket-change indication, high resets all registers |
| wd_rst_n_i | input | 1 | Watchdog reset output, active low |
| core_current_i | input | CUR_W | Measured core current code |
| sda_drive_o | output | 1 | Pull the data line low when 1 (open drain) |
| offset_code_o | output | 5 | Stored offset code |
| offset_mv_o | output | 10 | Offset in millivolts decoded from the code |
| wd_enable_o | output | 1 | Watchdog-reset enable bit |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 7-bit current field and revision 0x00. At that size every one of the 128 seven-bit addresses can be probed, under both strap settings of the low bit, and all 32 offset codes can be written, read back and compared with the millivolt decode. The sticky flags are driven through every mix of write-0, write-1, watchdog pulse with the enable set and cleared, and socket pulse. These sequences show which events set or clear each flag.

// File: rtl/vreg_cfg_pkg.sv
package vreg_cfg_pkg;

    localparam int OFS_W    = 5;
    localparam int OFS_MV_W = 10;
    localparam int CTRL_W   = 3;

    localparam logic [5:0] DEV_ADDR_HI = 6'b010111;

    localparam logic [7:0] IDX_OFFSET   = 8'h00;
    localparam logic [7:0] IDX_CURRENT  = 8'h01;
    localparam logic [7:0] IDX_CTRL     = 8'h03;
    localparam logic [7:0] IDX_REVISION = 8'h13;

    localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_INDEX,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK
    } xfer_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] index;
        logic [7:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [6:0] dev_addr(input logic sel);
        return {DEV_ADDR_HI, sel};
    endfunction

    function automatic logic [OFS_MV_W-1:0] offset_millivolts(input logic [OFS_W-1:0] code);
        if (&code)
            return OFS_MV_W'(800);
        return OFS_MV_W'(code) * OFS_MV_W'(25);
    endfunction

endpackage

// File: rtl/vreg_bus_sync.sv
module vreg_bus_sync
    import vreg_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[TOP];
            sda_d <= sda_q[TOP];
        end
    end

    always_comb begin
        evt.sda      = sda_q[TOP];
        evt.scl_rise = scl_q[TOP] & ~scl_d;
        evt.scl_fall = ~scl_q[TOP] & scl_d;
        evt.start    = scl_q[TOP] & scl_d & sda_d & ~sda_q[TOP];
        evt.stop     = scl_q[TOP] & scl_d & ~sda_d & sda_q[TOP];
    end

endmodule

// File: rtl/vreg_bus_engine.sv
module vreg_bus_engine
    import vreg_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output reg_wr_t    wr,
    output logic [7:0] rd_index,
    output logic       sda_drive
);
    xfer_state_e state, after;
    logic [2:0]  cnt;
    logic [7:0]  shreg;
    logic        have_byte;

    always_ff @(posedge clk) begin
        wr.valid <= 1'b0;
        if (rst) begin
            state     <= ST_IDLE;
            after     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            have_byte <= 1'b0;
            sda_drive <= 1'b0;
            rd_index  <= '0;
            wr.index  <= '0;
            wr.data   <= '0;
        end else if (evt.stop) begin
            state     <= ST_IDLE;
            have_byte <= 1'b0;
            sda_drive <= 1'b0;
        end else if (evt.start) begin
            state     <= ST_DEVADDR;
            cnt       <= '0;
            have_byte <= 1'b0;
            sda_drive <= 1'b0;
        end else if (evt.scl_rise) begin
            case (state)
                ST_DEVADDR, ST_INDEX, ST_WDATA: begin
                    shreg <= {shreg[6:0], evt.sda};
                    cnt   <= cnt + 3'd1;
                    if (cnt == 3'd7) have_byte <= 1'b1;
                end
                ST_RDATA: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) have_byte <= 1'b1;
                end
                ST_MACK: begin
                    if (evt.sda) state <= ST_IDLE;
                    else         have_byte <= 1'b1;
                end
                default: ;
            endcase
        end else if (evt.scl_fall) begin
            case (state)
                ST_DEVADDR: if (have_byte) begin
                    have_byte <= 1'b0;
                    if (shreg[7:1] == dev_addr(addr_sel)) begin
                        sda_drive <= 1'b1;
                        state     <= ST_SACK;
                        after     <= shreg[0] ? ST_RDATA : ST_INDEX;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_INDEX: if (have_byte) begin
                    have_byte <= 1'b0;
                    rd_index  <= shreg;
                    sda_drive <= 1'b1;
                    state     <= ST_SACK;
                    after     <= ST_WDATA;
                end
                ST_WDATA: if (have_byte) begin
                    have_byte <= 1'b0;
                    wr.valid  <= 1'b1;
                    wr.index  <= rd_index;
                    wr.data   <= shreg;
                    sda_drive <= 1'b1;
                    state     <= ST_SACK;
                    after     <= ST_WDATA;
                end
                ST_SACK: begin
                    state <= after;
                    cnt   <= '0;
                    if (after == ST_RDATA) begin
                        shreg     <= rd_data;
                        sda_drive <= ~rd_data[7];
                    end else begin
                        sda_drive <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (have_byte) begin
                        have_byte <= 1'b0;
                        sda_drive <= 1'b0;
                        state     <= ST_MACK;
                    end else begin
                        shreg     <= {shreg[6:0], 1'b0};
                        sda_drive <= ~shreg[6];
                    end
                end
                ST_MACK: if (have_byte) begin
                    have_byte <= 1'b0;
                    state     <= ST_RDATA;
                    cnt       <= '0;
                    shreg     <= rd_data;
                    sda_drive <= ~rd_data[7];
                end
                default: ;
            endcase
        end
    end

    // R2: an idle or unaddressed slave never pulls the data line
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_drive);

    // R10: every accepted data byte is acknowledged as it is committed
    a_r10_write_acked: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> (state == ST_SACK && sda_drive));

endmodule

// File: rtl/vreg_reg_file.sv
module vreg_reg_file
    import vreg_cfg_pkg::*;
#(
    parameter int         CUR_W  = 7,
    parameter logic [7:0] REV_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [7:0]        rd_index,
    input  logic [CUR_W-1:0]  core_current,
    input  logic              socket_occ,
    input  logic              wd_rst_n,
    output logic [7:0]        rd_data,
    output logic [OFS_W-1:0]  offset_code,
    output logic              wd_enable
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              wd_hit;

    assign wd_hit      = ~wd_rst_n & ctrl_q[0];
    assign offset_code = ofs_q;
    assign wd_enable   = ctrl_q[0];

    always_ff @(posedge clk) begin
        if (rst || socket_occ) begin
            ofs_q  <= '0;
            ctrl_q <= CTRL_DEFAULT;
        end else if (wd_hit) begin
            ofs_q     <= '0;
            ctrl_q[1] <= 1'b1;
        end else if (wr.valid) begin
            case (wr.index)
                IDX_OFFSET: ofs_q <= wr.data[OFS_W-1:0];
                IDX_CTRL:   ctrl_q <= {ctrl_q[2] & wr.data[2],
                                       ctrl_q[1] & wr.data[1],
                                       wr.data[0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_index)
            IDX_OFFSET:   rd_data[OFS_W-1:0]  = ofs_q;
            IDX_CURRENT:  rd_data[CUR_W-1:0]  = core_current;
            IDX_CTRL:     rd_data[CTRL_W-1:0] = ctrl_q;
            IDX_REVISION: rd_data             = REV_ID;
            default:      rd_data             = '0;
        endcase
    end

    // R8: socket change restores every default
    a_r8_socket_defaults: assert property (@(posedge clk) disable iff (rst)
        socket_occ |=> (ofs_q == '0 && ctrl_q == CTRL_DEFAULT));

    // R9: watchdog pulse clears the offset, flags the reset, keeps the enable
    a_r9_wd_spares_ctrl: assert property (@(posedge clk) disable iff (rst)
        (!socket_occ && wd_hit) |=> (ofs_q == '0 && ctrl_q[1] && ctrl_q[0]));

    // R6: the socket flag is never set by a write
    a_r6_socket_flag_clear_only: assert property (@(posedge clk) disable iff (rst)
        (!socket_occ && !ctrl_q[2]) |=> !ctrl_q[2]);

    // R6: the reset-issued flag is only set by a watchdog pulse
    a_r6_issue_flag_clear_only: assert property (@(posedge clk) disable iff (rst)
        (!socket_occ && !wd_hit && !ctrl_q[1]) |=> !ctrl_q[1]);

endmodule

// File: rtl/vreg_cfg_slave.sv
module vreg_cfg_slave
    import vreg_cfg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         CUR_W       = 7,
    parameter logic [7:0] REV_ID      = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                addr_sel_i,
    input  logic                socket_occ_i,
    input  logic                wd_rst_n_i,
    input  logic [CUR_W-1:0]    core_current_i,
    output logic                sda_drive_o,
    output logic [OFS_W-1:0]    offset_code_o,
    output logic [OFS_MV_W-1:0] offset_mv_o,
    output logic                wd_enable_o
);
    bus_evt_t   evt;
    reg_wr_t    wr;
    logic [7:0] rd_index;
    logic [7:0] rd_data;

    vreg_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    vreg_bus_engine engine_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .addr_sel  (addr_sel_i),
        .rd_data   (rd_data),
        .wr        (wr),
        .rd_index  (rd_index),
        .sda_drive (sda_drive_o)
    );

    vreg_reg_file #(.CUR_W(CUR_W), .REV_ID(REV_ID)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .rd_index     (rd_index),
        .core_current (core_current_i),
        .socket_occ   (socket_occ_i),
        .wd_rst_n     (wd_rst_n_i),
        .rd_data      (rd_data),
        .offset_code  (offset_code_o),
        .wd_enable    (wd_enable_o)
    );

    assign offset_mv_o = offset_millivolts(offset_code_o);

endmodule

// File: tb/vreg_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module vreg_cfg_slave_tb_top;

    localparam int Q     = 6;
    localparam int LIMIT = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_sel = 1'b1;
    logic       socket = 1'b0;
    logic       wd_n = 1'b1;
    logic [6:0] cur = 7'h2A;
    logic       drive;
    logic       sda_line;
    logic [4:0] ofs_code;
    logic [9:0] ofs_mv;
    logic       wd_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    assign sda_line = m_sda & ~drive;

    always #5 clk = ~clk;

    vreg_cfg_slave dut_i (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (m_scl),
        .sda_i          (sda_line),
        .addr_sel_i     (addr_sel),
        .socket_occ_i   (socket),
        .wd_rst_n_i     (wd_n),
        .core_current_i (cur),
        .sda_drive_o    (drive),
        .offset_code_o  (ofs_code),
        .offset_mv_o    (ofs_mv),
        .wd_enable_o    (wd_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b1; wait_q(1);
    endtask

    task automatic wbit(input logic b);
        m_sda = b;    wait_q(1);
        m_scl = 1'b1; wait_q(2);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        b = sda_line; wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic wbyte(input logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(a);
        acked = !a;
    endtask

    task automatic rbyte(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) rbit(d[i]);
    endtask

    function automatic logic [7:0] addr8(input logic sel, input logic rd);
        return {6'b010111, sel, rd};
    endfunction

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] d, output bit ok);
        bit a0, a1, a2;
        bus_start();
        wbyte(addr8(addr_sel, 1'b0), a0);
        wbyte(idx, a1);
        wbyte(d, a2);
        bus_stop();
        ok = a0 && a1 && a2;
    endtask

    task automatic read_reg(input logic [7:0] idx, input int n,
                            output logic [7:0] first, output logic [7:0] last, output bit ok);
        bit a0, a1, a2;
        logic [7:0] d;
        bus_start();
        wbyte(addr8(addr_sel, 1'b0), a0);
        wbyte(idx, a1);
        bus_start();
        wbyte(addr8(addr_sel, 1'b1), a2);
        first = '0;
        for (int k = 0; k < n; k++) begin
            rbyte(d);
            if (k == 0) first = d;
            wbit(k == n - 1);
        end
        last = d;
        bus_stop();
        ok = a0 && a1 && a2;
    endtask

    task automatic expect_reg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        logic [7:0] f, l;
        bit ok;
        read_reg(idx, 1, f, l, ok);
        chk(ok, {tag, " read acks"}, ok, 1);
        chk(f == exp, tag, f, exp);
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] d, input string tag);
        bit ok;
        write_reg(idx, d, ok);
        chk(ok, {tag, " write acks"}, ok, 1);
    endtask

    initial begin : main
        bit ok;
        logic [7:0] f, l;
        int expmv;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(ofs_code == 5'd0, "R1 offset code", ofs_code, 0);
        chk(ofs_mv == 10'd0, "R1 offset mv", ofs_mv, 0);
        chk(wd_en == 1'b0, "R1 wd enable", wd_en, 0);
        chk(drive == 1'b0, "R1 sda idle", drive, 0);
        expect_reg(8'h00, 8'h00, "R1 idx00");
        expect_reg(8'h03, 8'h04, "R1 idx03");
        expect_reg(8'h13, 8'h00, "R1 idx13");

        // R2: address sweep with strap = 1, then strap = 0
        for (int a = 0; a < 128; a++) begin
            bit ack;
            bus_start();
            wbyte({a[6:0], 1'b0}, ack);
            bus_stop();
            chk(ack == (a == 'h2F), "R2 address ack strap1", ack, (a == 'h2F));
        end
        addr_sel = 1'b0;
        for (int a = 'h2E; a <= 'h2F; a++) begin
            bit ack;
            bus_start();
            wbyte({a[6:0], 1'b0}, ack);
            bus_stop();
            chk(ack == (a == 'h2E), "R2 address ack strap0", ack, (a == 'h2E));
        end
        expect_reg(8'h03, 8'h04, "R2 strap0 access");
        addr_sel = 1'b1;
        // R2: a transfer to another device changes nothing
        begin
            bit a0, a1, a2;
            bus_start();
            wbyte(8'h5C, a0);
            wbyte(8'h00, a1);
            wbyte(8'h15, a2);
            bus_stop();
            chk(!a0 && !a1 && !a2, "R2 foreign transfer not acked", {a0, a1, a2}, 0);
            chk(ofs_code == 5'd0, "R2 foreign write ignored", ofs_code, 0);
        end

        // R3, R4: all offset codes, upper data bits set to 101
        for (int c = 0; c < 32; c++) begin
            do_write(8'h00, {3'b101, c[4:0]}, "R3 offset");
            expect_reg(8'h00, {3'b000, c[4:0]}, "R3 offset readback");
            chk(ofs_code == c[4:0], "R3 offset port", ofs_code, c);
            expmv = (c == 31) ? 800 : c * 25;
            chk(ofs_mv == expmv[9:0], "R4 offset millivolts", ofs_mv, expmv);
        end

        // R10: master ACK repeats the same register, NACK ends
        do_write(8'h00, 8'h0B, "R10 setup");
        read_reg(8'h00, 3, f, l, ok);
        chk(ok, "R10 read acks", ok, 1);
        chk(f == 8'h0B && l == 8'h0B, "R10 repeated bytes", {f, l}, 16'h0B0B);
        chk(drive == 1'b0, "R10 released after read", drive, 0);

        // R5: current register
        for (int v = 0; v < 3; v++) begin
            logic [6:0] cv;
            cv = (v == 0) ? 7'h00 : (v == 1) ? 7'h7F : 7'h55;
            cur = cv;
            expect_reg(8'h01, {1'b0, cv}, "R5 current");
        end
        do_write(8'h01, 8'hFF, "R5 write");
        expect_reg(8'h01, 8'h55, "R5 write ignored");

        // R7: revision, unimplemented indices
        do_write(8'h13, 8'hAA, "R7 rev write");
        expect_reg(8'h13, 8'h00, "R7 revision");
        do_write(8'h02, 8'h5A, "R7 unimpl write");
        do_write(8'hFF, 8'h1F, "R7 unimpl write ff");
        expect_reg(8'h02, 8'h00, "R7 idx02");
        expect_reg(8'h10, 8'h00, "R7 idx10");
        expect_reg(8'hFF, 8'h00, "R7 idxff");
        expect_reg(8'h00, 8'h0B, "R7 offset untouched");
        expect_reg(8'h03, 8'h04, "R7 ctrl untouched");

        // R6: control bits
        do_write(8'h03, 8'h07, "R6 w07");
        expect_reg(8'h03, 8'h05, "R6 set enable keep flag");
        chk(wd_en == 1'b1, "R6 wd enable port", wd_en, 1);
        do_write(8'h03, 8'h01, "R6 w01");
        expect_reg(8'h03, 8'h01, "R6 clear socket flag");
        do_write(8'h03, 8'h07, "R6 w07b");
        expect_reg(8'h03, 8'h01, "R6 flags not settable");

        // R9: watchdog pulse with enable set
        do_write(8'h00, 8'h09, "R9 setup");
        @(negedge clk); wd_n = 1'b0;
        repeat (4) @(negedge clk); wd_n = 1'b1;
        @(negedge clk);
        chk(ofs_code == 5'd0, "R9 offset cleared", ofs_code, 0);
        chk(wd_en == 1'b1, "R9 enable kept", wd_en, 1);
        expect_reg(8'h03, 8'h03, "R9 issue flag set");
        do_write(8'h03, 8'h05, "R6 w05");
        expect_reg(8'h03, 8'h01, "R6 clear issue flag");
        do_write(8'h03, 8'h00, "R6 w00");
        expect_reg(8'h03, 8'h00, "R6 all clear");

        // R9: watchdog pulse with enable clear has no effect
        do_write(8'h00, 8'h07, "R9 setup2");
        @(negedge clk); wd_n = 1'b0;
        repeat (4) @(negedge clk); wd_n = 1'b1;
        @(negedge clk);
        chk(ofs_code == 5'd7, "R9 disabled offset kept", ofs_code, 7);
        expect_reg(8'h03, 8'h00, "R9 disabled ctrl kept");

        // R8: socket change
        do_write(8'h03, 8'h01, "R8 setup");
        @(negedge clk); socket = 1'b1;
        repeat (3) @(negedge clk); socket = 1'b0;
        @(negedge clk);
        chk(ofs_code == 5'd0, "R8 offset default", ofs_code, 0);
        chk(wd_en == 1'b0, "R8 enable default", wd_en, 0);
        expect_reg(8'h03, 8'h04, "R8 ctrl default");
        expect_reg(8'h00, 8'h00, "R8 offset readback");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule